// File: doc/BRIEF.md
# PID-tagged virtual cache tag array

This block holds the tags and per-line state of a direct-mapped cache that is indexed and tagged with virtual addresses. A lookup carries a virtual address, the identifier of the running process and the kind of access. The hit, miss and fault results come back in the same cycle, with no address translation on the path. Each line stores a valid bit, a dirty bit, the upper virtual address bits, the owning process identifier and three permission bits. The permission bits are taken from the translation buffer when the line is filled.

Lines are tied to a process identifier, so a context switch needs no invalidation. Lines of another process simply stop matching. When the operating system recycles an identifier, it requests a flush for that identifier. A walker then visits every set, one per cycle, and invalidates only the lines owned by that identifier. The stored permissions are checked on every hit. A lookup that matches a line but is not permitted is reported as a fault, not as a hit, and a write that faults leaves the line unchanged.

Top module: `vc_tag_array`

## Requirements
- R1: After reset every line is invalid, so every lookup reports a miss, and the flush busy output is low.
- R2: The address fields are as follows: the set index is address bits [11:5] and the tag is bits [31:12]. A lookup hits in the same cycle only if the selected line is valid, its tag equals the lookup tag, its stored identifier equals the lookup identifier, and the access is permitted.
- R3: A line whose tag matches but whose stored identifier differs from the lookup identifier reports a miss. The line stays intact, and a later lookup from its owner still hits.
- R4: A fill that is accepted (fill request high, flush busy low) writes the tag, identifier and permission bits of its set at the clock edge. The line is valid with dirty clear from the next cycle.
- R5: Permission field bit 0 allows reads, bit 1 allows writes and bit 2 allows execution. The access kind codes are 0 read, 1 write, 2 execute and 3 treated as a read. A matching lookup whose kind is not allowed raises the fault output, with hit and miss low.
- R6: A permitted write hit sets the line's dirty bit, and a faulting write does not set it. The dirty output shows the stored dirty bit of a matching line whenever hit or fault is high, and is low otherwise.
- R7: A flush request accepted while idle raises busy in the next cycle. Busy then stays high for exactly 128 cycles, one set visited per cycle.
- R8: A flush invalidates exactly the lines whose stored identifier equals the flush identifier. Lines of every other identifier remain valid.
- R9: While busy is high, the following hold: lookups drive hit, miss and fault low; fill requests are dropped; and further flush requests are ignored.
- R10: At most one of hit, miss and fault is high at a time, and all three are low when no lookup is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_pid | input | 8 | Identifier of the running process |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| lk_hit | output | 1 | Permitted hit |
| lk_miss | output | 1 | No matching line |
| lk_fault | output | 1 | Matching line, access not permitted |
| lk_dirty | output | 1 | Dirty bit of the matching line |
| fill_en | input | 1 | Write a line |
| fill_vaddr | input | 32 | Virtual address of the line being filled |
| fill_pid | input | 8 | Owner identifier written into the line |
| fill_prot | input | 3 | Permission bits from the translation buffer |
| flush_req | input | 1 | Start a flush of one identifier |
| flush_pid | input | 8 | Identifier to invalidate |
| flush_busy | output | 1 | Flush walk in progress |

## Verification
Random lookups and fills draw from a small pool of sets, tags and identifiers, so the following cases all occur often: true hits, tag-only matches from another process, tag mismatches and permission faults. Each outcome is compared against a bench model of the lines. Directed sequences separate a read from a faulting write on the same line, and show whether the dirty bit tracks only permitted writes. A flush is directed at lines of two identifiers placed in the first, last and middle sets. While the flush runs, a lookup, a fill and a second flush are applied. This shows that the walk is selective, that it lasts exactly one pass, and that the other requests have no effect during it.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int VA_W       = 32;
    localparam int LINE_BYTES = 32;
    localparam int SETS       = 128;
    localparam int PID_W      = 8;
    localparam int PERM_W     = 3;

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VA_W - OFF_W - IDX_W;

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    typedef logic [VA_W-1:0]   vaddr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [PID_W-1:0]  pid_t;
    typedef logic [PERM_W-1:0] perm_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef struct packed {
        logic  valid;
        logic  dirty;
        tag_t  tag;
        pid_t  pid;
        perm_t perm;
    } line_t;

    function automatic idx_t set_of(input vaddr_t va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(input vaddr_t va);
        return va[VA_W-1 -: TAG_W];
    endfunction

    function automatic logic access_ok(input perm_t perm, input acc_e kind);
        logic ok;
        case (kind)
            ACC_WRITE: ok = perm[PERM_WR];
            ACC_EXEC:  ok = perm[PERM_EX];
            default:   ok = perm[PERM_RD];
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/vc_tag_store.sv
module vc_tag_store
    import vc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    output line_t rd_line,
    input  logic  clr_en,
    input  idx_t  clr_idx,
    input  pid_t  clr_pid,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  line_t wr_line,
    input  logic  mark_en,
    input  idx_t  mark_idx
);

    line_t lines [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        line_t q;
        logic  hit_clr, hit_wr, hit_mark;

        assign hit_clr  = clr_en  && (clr_idx  == idx_t'(s));
        assign hit_wr   = wr_en   && (wr_idx   == idx_t'(s));
        assign hit_mark = mark_en && (mark_idx == idx_t'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                q.valid <= 1'b0;
                q.dirty <= 1'b0;
            end else if (hit_clr) begin
                if (q.valid && (q.pid == clr_pid)) begin
                    q.valid <= 1'b0;
                end
            end else if (hit_wr) begin
                q <= wr_line;
            end else if (hit_mark) begin
                q.dirty <= 1'b1;
            end
        end

        assign lines[s] = q;
    end

    assign rd_line = lines[rd_idx];

endmodule

// File: rtl/vc_lookup.sv
module vc_lookup
    import vc_pkg::*;
(
    input  logic  en,
    input  line_t line,
    input  tag_t  tag,
    input  pid_t  pid,
    input  acc_e  kind,
    output logic  hit,
    output logic  miss,
    output logic  fault,
    output logic  dirty,
    output logic  mark
);

    logic match;
    logic ok;

    always_comb begin
        match = en && line.valid && (line.tag == tag) && (line.pid == pid);
        ok    = access_ok(line.perm, kind);
        hit   = match && ok;
        fault = match && !ok;
        miss  = en && !match;
        dirty = match && line.dirty;
        mark  = hit && (kind == ACC_WRITE);
    end

endmodule

// File: rtl/vc_flush_walker.sv
module vc_flush_walker
    import vc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  pid_t req_pid,
    output logic busy,
    output idx_t ptr,
    output pid_t tgt_pid
);

    localparam idx_t LAST = idx_t'(SETS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            ptr     <= '0;
            tgt_pid <= '0;
        end else if (!busy) begin
            if (req) begin
                busy    <= 1'b1;
                ptr     <= '0;
                tgt_pid <= req_pid;
            end
        end else if (ptr == LAST) begin
            busy <= 1'b0;
        end else begin
            ptr <= ptr + idx_t'(1);
        end
    end

endmodule

// File: rtl/vc_tag_array.sv
module vc_tag_array
    import vc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [1:0]        lk_kind,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic              lk_dirty,
    input  logic              fill_en,
    input  logic [VA_W-1:0]   fill_vaddr,
    input  logic [PID_W-1:0]  fill_pid,
    input  logic [PERM_W-1:0] fill_prot,
    input  logic              flush_req,
    input  logic [PID_W-1:0]  flush_pid,
    output logic              flush_busy
);

    idx_t  walk_idx;
    pid_t  walk_pid;
    line_t rd_line;
    line_t new_line;
    logic  lk_en;
    logic  fill_go;
    logic  mark;

    assign lk_en   = lk_valid && !flush_busy;
    assign fill_go = fill_en && !flush_busy;

    always_comb begin
        new_line.valid = 1'b1;
        new_line.dirty = 1'b0;
        new_line.tag   = tag_of(fill_vaddr);
        new_line.pid   = fill_pid;
        new_line.perm  = fill_prot;
    end

    vc_flush_walker u_walk (
        .clk     (clk),
        .rst     (rst),
        .req     (flush_req),
        .req_pid (flush_pid),
        .busy    (flush_busy),
        .ptr     (walk_idx),
        .tgt_pid (walk_pid)
    );

    vc_tag_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (set_of(lk_vaddr)),
        .rd_line  (rd_line),
        .clr_en   (flush_busy),
        .clr_idx  (walk_idx),
        .clr_pid  (walk_pid),
        .wr_en    (fill_go),
        .wr_idx   (set_of(fill_vaddr)),
        .wr_line  (new_line),
        .mark_en  (mark),
        .mark_idx (set_of(lk_vaddr))
    );

    vc_lookup u_look (
        .en    (lk_en),
        .line  (rd_line),
        .tag   (tag_of(lk_vaddr)),
        .pid   (lk_pid),
        .kind  (acc_e'(lk_kind)),
        .hit   (lk_hit),
        .miss  (lk_miss),
        .fault (lk_fault),
        .dirty (lk_dirty),
        .mark  (mark)
    );

endmodule

// File: rtl/vc_tag_array_chk.sv
module vc_tag_array_chk
    import vc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [PID_W-1:0]  lk_pid,
    input logic [1:0]        lk_kind,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_fault,
    input logic              lk_dirty,
    input logic              fill_en,
    input logic [VA_W-1:0]   fill_vaddr,
    input logic [PID_W-1:0]  fill_pid,
    input logic [PERM_W-1:0] fill_prot,
    input logic              flush_req,
    input logic              flush_busy
);

    logic                 seen;
    logic [IDX_W:0]       busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen     <= 1'b0;
            busy_cnt <= '0;
        end else begin
            seen     <= 1'b1;
            busy_cnt <= flush_busy ? busy_cnt + 1'b1 : '0;
        end
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        flush_busy |-> !(lk_hit || lk_miss || lk_fault));

    p_start_r7: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !flush_busy) |=> flush_busy);

    p_len_r7: assert property (@(posedge clk) disable iff (rst)
        (seen && $fell(flush_busy)) |-> (busy_cnt == (IDX_W+1)'(SETS)));

    p_dirty_scope_r6: assert property (@(posedge clk) disable iff (rst)
        lk_dirty |-> (lk_hit || lk_fault));

    p_fill_visible_r4: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(fill_en && !flush_busy) && !flush_busy && lk_valid
         && lk_vaddr == $past(fill_vaddr) && lk_pid == $past(fill_pid)
         && lk_kind == 2'd0 && $past(fill_prot[PERM_RD]))
        |-> (lk_hit && !lk_dirty));

endmodule

bind vc_tag_array vc_tag_array_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_pid     (lk_pid),
    .lk_kind    (lk_kind),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_fault   (lk_fault),
    .lk_dirty   (lk_dirty),
    .fill_en    (fill_en),
    .fill_vaddr (fill_vaddr),
    .fill_pid   (fill_pid),
    .fill_prot  (fill_prot),
    .flush_req  (flush_req),
    .flush_busy (flush_busy)
);

// File: tb/vc_tag_array_test.sv
module vc_tag_array_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty;
    logic        fill_en = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic [7:0]  fill_pid = '0;
    logic [2:0]  fill_prot = '0;
    logic        flush_req = 1'b0;
    logic [7:0]  flush_pid = '0;
    logic        flush_busy;

    int checks = 0;
    int errors = 0;

    bit          m_v   [128];
    bit          m_d   [128];
    logic [19:0] m_tag [128];
    logic [7:0]  m_pid [128];
    logic [2:0]  m_prot[128];

    always #5 clk = ~clk;

    vc_tag_array uut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_kind(lk_kind),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_dirty(lk_dirty),
        .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_pid(fill_pid), .fill_prot(fill_prot),
        .flush_req(flush_req), .flush_pid(flush_pid), .flush_busy(flush_busy)
    );

    function automatic logic [31:0] mk_va(input logic [19:0] tag, input logic [6:0] idx,
                                          input logic [4:0] off);
        return {tag, idx, off};
    endfunction

    // expected {hit, miss, fault, dirty}
    function automatic logic [3:0] expect_lk(input logic [31:0] va, input logic [7:0] pid,
                                             input logic [1:0] kind);
        logic [6:0] i;
        logic       match, ok;
        i     = va[11:5];
        match = m_v[i] && (m_tag[i] == va[31:12]) && (m_pid[i] == pid);
        case (kind)
            2'd1:    ok = m_prot[i][1];
            2'd2:    ok = m_prot[i][2];
            default: ok = m_prot[i][0];
        endcase
        return {match && ok, !match, match && !ok, match && m_d[i]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_lookup(input string req, input logic [31:0] va,
                             input logic [7:0] pid, input logic [1:0] kind);
        logic [3:0] e;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_pid = pid; lk_kind = kind;
        #1;
        e = expect_lk(va, pid, kind);
        check(req, "lookup {hit,miss,fault,dirty}",
              {28'd0, lk_hit, lk_miss, lk_fault, lk_dirty}, {28'd0, e});
        @(posedge clk);
        if (e[3] && kind == 2'd1) m_d[va[11:5]] = 1'b1;
        #1 lk_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [7:0] pid, input logic [2:0] prot);
        @(negedge clk);
        fill_en = 1'b1; fill_vaddr = va; fill_pid = pid; fill_prot = prot;
        @(posedge clk);
        m_v[va[11:5]] = 1'b1; m_d[va[11:5]] = 1'b0;
        m_tag[va[11:5]] = va[31:12]; m_pid[va[11:5]] = pid; m_prot[va[11:5]] = prot;
        #1 fill_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [6:0] pool [6];
        int         cnt;
        pool = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd126, 7'd127};
        void'($urandom(32'd2024));
        for (int i = 0; i < 128; i++) begin m_v[i] = 1'b0; m_d[i] = 1'b0; end

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk); #1;
        check("R1", "busy after reset", {31'd0, flush_busy}, 32'd0);
        check("R10", "outputs idle", {29'd0, lk_hit, lk_miss, lk_fault}, 32'd0);
        do_lookup("R1", mk_va(20'h0, 7'd0, 5'd0), 8'd0, 2'd0);
        do_lookup("R1", mk_va(20'h0, 7'd127, 5'd3), 8'd1, 2'd2);

        // R4 fill then hit next cycle, R2 same-cycle hit
        do_fill(mk_va(20'h100, 7'd3, 5'd0), 8'd1, 3'b111);
        do_lookup("R4", mk_va(20'h100, 7'd3, 5'd9), 8'd1, 2'd0);
        do_lookup("R2", mk_va(20'h101, 7'd3, 5'd9), 8'd1, 2'd0);
        // R3 other process, same address
        do_lookup("R3", mk_va(20'h100, 7'd3, 5'd9), 8'd2, 2'd0);
        do_lookup("R3", mk_va(20'h100, 7'd3, 5'd1), 8'd1, 2'd2);

        // R5 / R6 permissions and dirty
        do_fill(mk_va(20'h200, 7'd2, 5'd0), 8'd1, 3'b001);
        do_lookup("R5", mk_va(20'h200, 7'd2, 5'd0), 8'd1, 2'd1);
        do_lookup("R5", mk_va(20'h200, 7'd2, 5'd0), 8'd1, 2'd2);
        do_lookup("R6", mk_va(20'h200, 7'd2, 5'd0), 8'd1, 2'd0);
        do_lookup("R5", mk_va(20'h200, 7'd2, 5'd0), 8'd1, 2'd3);
        do_fill(mk_va(20'h201, 7'd1, 5'd0), 8'd1, 3'b011);
        do_lookup("R6", mk_va(20'h201, 7'd1, 5'd0), 8'd1, 2'd1);
        do_lookup("R6", mk_va(20'h201, 7'd1, 5'd0), 8'd1, 2'd0);
        do_lookup("R5", mk_va(20'h201, 7'd1, 5'd0), 8'd1, 2'd2);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] va;
            logic [7:0]  pid;
            va  = mk_va(20'h100 + 20'($urandom % 4), pool[$urandom % 6], 5'($urandom));
            pid = 8'(1 + $urandom % 3);
            if ($urandom % 4 == 0) do_fill(va, pid, 3'($urandom));
            else do_lookup("R2", va, pid, 2'($urandom % 4));
        end

        // flush setup
        do_fill(mk_va(20'h300, 7'd0,   5'd0), 8'd1, 3'b111);
        do_fill(mk_va(20'h301, 7'd127, 5'd0), 8'd1, 3'b111);
        do_fill(mk_va(20'h302, 7'd6,   5'd0), 8'd1, 3'b111);
        do_fill(mk_va(20'h303, 7'd5,   5'd0), 8'd2, 3'b111);
        do_fill(mk_va(20'h304, 7'd64,  5'd0), 8'd2, 3'b111);
        do_fill(mk_va(20'h305, 7'd1,   5'd0), 8'd2, 3'b111);

        @(negedge clk);
        flush_req = 1'b1; flush_pid = 8'd1;
        #1 check("R7", "busy before accept", {31'd0, flush_busy}, 32'd0);
        @(posedge clk);
        #1 flush_req = 1'b0;
        cnt = 0;
        for (int guard = 0; guard < 1000; guard++) begin
            @(negedge clk);
            lk_valid = (cnt == 5);
            lk_vaddr = mk_va(20'h303, 7'd5, 5'd0); lk_pid = 8'd2; lk_kind = 2'd0;
            fill_en = (cnt == 10);
            fill_vaddr = mk_va(20'h3aa, 7'd50, 5'd0); fill_pid = 8'd3; fill_prot = 3'b111;
            flush_req = (cnt == 20); flush_pid = 8'd2;
            #1;
            if (!flush_busy) break;
            if (cnt == 5)
                check("R9", "lookup outputs while busy",
                      {29'd0, lk_hit, lk_miss, lk_fault}, 32'd0);
            cnt++;
        end
        lk_valid = 1'b0; fill_en = 1'b0; flush_req = 1'b0;
        check("R7", "busy length", cnt, 32'd128);
        for (int i = 0; i < 128; i++) if (m_pid[i] == 8'd1) m_v[i] = 1'b0;

        do_lookup("R8", mk_va(20'h300, 7'd0,   5'd0), 8'd1, 2'd0);
        do_lookup("R8", mk_va(20'h301, 7'd127, 5'd0), 8'd1, 2'd0);
        do_lookup("R8", mk_va(20'h302, 7'd6,   5'd0), 8'd1, 2'd0);
        do_lookup("R8", mk_va(20'h303, 7'd5,   5'd0), 8'd2, 2'd0);
        do_lookup("R8", mk_va(20'h304, 7'd64,  5'd0), 8'd2, 2'd0);
        do_lookup("R9", mk_va(20'h305, 7'd1,   5'd0), 8'd2, 2'd0);
        do_lookup("R9", mk_va(20'h3aa, 7'd50,  5'd0), 8'd3, 2'd0);
        @(negedge clk); #1;
        check("R9", "second flush ignored", {31'd0, flush_busy}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule